// File: doc/BRIEF.md
# Three-Level Space-Vector Sector, Region and Dwell-Time Calculator

This block serves the modulator of a three-level neutral-point-clamped inverter. Each sampling period, a control loop gives it the angle of the reference voltage vector and a modulation index. The block reduces the angle to one of six 60-degree sectors and an angle inside that sector. It then finds which of the four triangles in the sector holds the tip of the reference. From this it derives the on-times of the three nearest stationary vectors, scaled so that they fill exactly one sampling period of `TS` counts. In the two inner triangles it also reports which of the two small vectors dominates, so that a later switching-sequence stage can choose its start state.

The data path is a three-stage pipeline with valid/ready handshakes on both sides. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. While the output is held back, the whole pipeline freezes and `in_ready` is low, so the back-pressure reaches the input in the same cycle. Sine values come from a quarter-wave table that is computed when the design elaborates.

Top module: `npc3_dwell_calc`

## Requirements
- R1: The angle code covers one turn in 768 steps, and each sector holds 128 steps. Codes from 768 upward wrap by subtracting 768. `out_sector` is floor(code/128) on the wrapped code: 0 to 5 stand for sectors I to VI. The angle inside the sector is the low 7 bits of the wrapped code, in steps of 60/128 degree.
- R2: `in_ma` is unsigned, and 2048 stands for an index of 1.0. Any code above 2048 gives exactly the result of 2048.
- R3: With m the index, θ the angle inside the sector, A = 2m·sinθ, B = 2m·sin(60°−θ) and C = A+B, the region is chosen as follows. Region 1 (code 0) applies when C ≤ 1. Otherwise region 2 (code 1) applies when A ≤ 1 and B ≤ 1. Otherwise region 3 (code 2) applies when B ≥ 1. Otherwise region 4 (code 3) applies. On a tie, the lower code wins.
- R4: The dwell times are (`out_ta`, `out_tb`, `out_tc`) = TS·(B, 1−C, A) in region 1, TS·(1−A, C−1, 1−B) in region 2, TS·(2−C, A, B−1) in region 3 and TS·(A−1, B, 2−C) in region 4. Each one lies within 4 counts of the exact value.
- R5: On every valid output, `out_ta + out_tb + out_tc` equals TS exactly.
- R6: Every dwell time lies between 0 and TS.
- R7: In regions 1 and 2, `out_sub` is 1 when the small vector at the sector's far edge has the longer time (A > B), and 0 otherwise. In regions 3 and 4, `out_sub` is 0.
- R8: With index code 1806 (about 0.882) and an in-sector angle near 49.2 degrees, the result is region 4 and each of the three times is close to TS/3.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold their values. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R10: With `out_ready` held high, the result of a request taken at edge k is transferred at edge k+3. Results leave in the order the requests came in.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_angle | input | 10 | Reference angle code, 768 per turn |
| in_ma | input | 12 | Modulation index, 2048 = 1.0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sector | output | 3 | Sector 0..5 |
| out_region | output | 2 | Region code 0..3 for regions 1..4 |
| out_sub | output | 1 | Dominant small vector in regions 1 and 2 |
| out_ta | output | 10 | First dwell time, counts of the sampling period |
| out_tb | output | 10 | Second dwell time |
| out_tc | output | 10 | Third dwell time |

## Verification
The bench builds the block with its default parameters: 128 angle steps per sector, a 12-bit index with 2048 as unity, and TS = 1000 counts. With these values the whole 10-bit angle range can be reached, including the wrap above code 767, and so can index codes well above unity, which exercise the clamp. TS = 1000 leaves enough resolution that every region and both sub-regions can be hit with margin away from their borders. The bench also runs a phase with a throttled `out_ready` to check that outputs hold and that results stay in order under back-pressure.

// File: rtl/npc3_dwell_pkg.sv
package npc3_dwell_pkg;
  typedef enum logic [1:0] {
    RGN_1 = 2'd0,
    RGN_2 = 2'd1,
    RGN_3 = 2'd2,
    RGN_4 = 2'd3
  } region_e;

  localparam int NUM_SECT = 6;
  localparam int NUM_RGN  = 4;
endpackage

// File: rtl/npc3_sine_rom.sv
module npc3_sine_rom #(
  parameter int SECT_LOG2 = 7,
  parameter int SIN_W     = 12,
  localparam int IDX_W    = SECT_LOG2 + 1
) (
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic [SIN_W-1:0] sin_a,
  output logic [SIN_W-1:0] sin_b
);
  localparam int SECT_STEPS = 1 << SECT_LOG2;
  localparam int QW         = (3 * SECT_STEPS) / 2;
  localparam int TBL_AW     = $clog2(QW + 1);
  localparam int ONE        = 1 << (SIN_W - 1);

  function automatic int sine_code(input int k);
    real ph;
    ph = 3.14159265358979 * real'(k) / real'(2 * QW);
    return $rtoi($sin(ph) * real'(ONE) + 0.5);
  endfunction

  function automatic logic [TBL_AW-1:0] fold(input logic [IDX_W-1:0] i);
    int k;
    k = int'(i);
    if (k > QW) k = 2 * QW - k;
    if (k < 0) k = 0;
    return TBL_AW'(k);
  endfunction

  logic [SIN_W-1:0] tbl [QW+1];

  for (genvar g = 0; g <= QW; g++) begin : g_tbl
    assign tbl[g] = SIN_W'(sine_code(g));
  end

  assign sin_a = tbl[fold(idx_a)];
  assign sin_b = tbl[fold(idx_b)];
endmodule

// File: rtl/npc3_angle_fold.sv
module npc3_angle_fold #(
  parameter int SECT_LOG2 = 7,
  parameter int ANG_W     = 10
) (
  input  logic [ANG_W-1:0]     angle,
  output logic [2:0]           sector,
  output logic [SECT_LOG2-1:0] theta
);
  localparam int FULL = npc3_dwell_pkg::NUM_SECT << SECT_LOG2;

  logic [ANG_W-1:0] wrapped;

  always_comb begin
    if (int'(angle) >= FULL) wrapped = angle - ANG_W'(FULL);
    else                     wrapped = angle;
  end

  assign sector = 3'(wrapped >> SECT_LOG2);
  assign theta  = wrapped[SECT_LOG2-1:0];
endmodule

// File: rtl/npc3_region_pick.sv
module npc3_region_pick #(
  parameter int TS  = 1000,
  localparam int T_W = $clog2(TS + 1)
) (
  input  logic [T_W:0]                   a_t,
  input  logic [T_W:0]                   b_t,
  output npc3_dwell_pkg::region_e        region,
  output logic                           sub,
  output logic [T_W-1:0]                 ta,
  output logic [T_W-1:0]                 tb,
  output logic [T_W-1:0]                 tc
);
  import npc3_dwell_pkg::*;

  localparam int S_W = T_W + 3;

  logic signed [S_W-1:0] sa, sb, sc, tsv, two;
  logic signed [S_W-1:0] c_a [NUM_RGN];
  logic signed [S_W-1:0] c_b [NUM_RGN];
  logic signed [S_W-1:0] c_c [NUM_RGN];
  logic [NUM_RGN-1:0]    fit;
  logic [1:0]            sel;

  assign sa  = $signed({2'b00, a_t});
  assign sb  = $signed({2'b00, b_t});
  assign sc  = sa + sb;
  assign tsv = $signed(S_W'(TS));
  assign two = tsv + tsv;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cand
    if (g == 0) begin : g_r1
      assign c_a[g] = sb;
      assign c_b[g] = tsv - sc;
      assign c_c[g] = sa;
    end else if (g == 1) begin : g_r2
      assign c_a[g] = tsv - sa;
      assign c_b[g] = sc - tsv;
      assign c_c[g] = tsv - sb;
    end else if (g == 2) begin : g_r3
      assign c_a[g] = two - sc;
      assign c_b[g] = sa;
      assign c_c[g] = sb - tsv;
    end else begin : g_r4
      assign c_a[g] = sa - tsv;
      assign c_b[g] = sb;
      assign c_c[g] = two - sc;
    end
    assign fit[g] = !c_a[g][S_W-1] && !c_b[g][S_W-1] && !c_c[g][S_W-1];
  end

  always_comb begin
    sel = 2'd3;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (fit[i]) sel = 2'(i);
    end
  end

  function automatic logic [T_W-1:0] sat(input logic signed [S_W-1:0] x);
    if (x < 0)   return '0;
    if (x > tsv) return T_W'(TS);
    return T_W'(x);
  endfunction

  assign ta     = sat(c_a[sel]);
  assign tb     = sat(c_b[sel]);
  assign tc     = sat(c_c[sel]);
  assign region = region_e'(sel);
  assign sub    = (sel <= 2'd1) && (sa > sb);
endmodule

// File: rtl/npc3_dwell_calc.sv
module npc3_dwell_calc #(
  parameter int SECT_LOG2 = 7,
  parameter int MA_W      = 12,
  parameter int SIN_W     = 12,
  parameter int TS        = 1000,
  localparam int ANG_W    = $clog2(npc3_dwell_pkg::NUM_SECT << SECT_LOG2),
  localparam int T_W      = $clog2(TS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ANG_W-1:0] in_angle,
  input  logic [MA_W-1:0]  in_ma,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_sector,
  output logic [1:0]       out_region,
  output logic             out_sub,
  output logic [T_W-1:0]   out_ta,
  output logic [T_W-1:0]   out_tb,
  output logic [T_W-1:0]   out_tc
);
  import npc3_dwell_pkg::*;

  localparam int SECT_STEPS = 1 << SECT_LOG2;
  localparam int IDX_W      = SECT_LOG2 + 1;
  localparam int MA_ONE     = 1 << (MA_W - 1);
  localparam int PROD_W     = MA_W + SIN_W + T_W;
  localparam int SHIFT      = (MA_W - 1) + (SIN_W - 1) - 1;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage 0 combinational: fold angle, clamp index, look up sines
  logic [2:0]           sect0;
  logic [SECT_LOG2-1:0] theta0;
  logic [IDX_W-1:0]     idx_a0, idx_b0;
  logic [SIN_W-1:0]     sin_a0, sin_b0;
  logic [MA_W-1:0]      ma0;

  npc3_angle_fold #(.SECT_LOG2(SECT_LOG2), .ANG_W(ANG_W)) u_fold (
    .angle (in_angle),
    .sector(sect0),
    .theta (theta0)
  );

  assign idx_a0 = {1'b0, theta0};
  assign idx_b0 = IDX_W'(SECT_STEPS) - {1'b0, theta0};
  assign ma0    = (int'(in_ma) > MA_ONE) ? MA_W'(MA_ONE) : in_ma;

  npc3_sine_rom #(.SECT_LOG2(SECT_LOG2), .SIN_W(SIN_W)) u_rom (
    .idx_a(idx_a0),
    .idx_b(idx_b0),
    .sin_a(sin_a0),
    .sin_b(sin_b0)
  );

  // stage 1 registers
  logic             v1;
  logic [2:0]       sect1;
  logic [MA_W-1:0]  ma1;
  logic [SIN_W-1:0] sin_a1, sin_b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; sect1 <= '0; ma1 <= '0; sin_a1 <= '0; sin_b1 <= '0;
    end else if (adv) begin
      v1     <= in_valid;
      sect1  <= sect0;
      ma1    <= ma0;
      sin_a1 <= sin_a0;
      sin_b1 <= sin_b0;
    end
  end

  // stage 1 combinational: scale products to sampling-period counts
  logic [PROD_W-1:0] prod_a, prod_b;
  logic [T_W:0]      a_t1, b_t1;

  assign prod_a = PROD_W'(ma1) * PROD_W'(sin_a1) * PROD_W'(TS);
  assign prod_b = PROD_W'(ma1) * PROD_W'(sin_b1) * PROD_W'(TS);
  assign a_t1   = (T_W+1)'(prod_a >> SHIFT);
  assign b_t1   = (T_W+1)'(prod_b >> SHIFT);

  // stage 2 registers
  logic         v2;
  logic [2:0]   sect2;
  logic [T_W:0] a_t2, b_t2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; sect2 <= '0; a_t2 <= '0; b_t2 <= '0;
    end else if (adv) begin
      v2    <= v1;
      sect2 <= sect1;
      a_t2  <= a_t1;
      b_t2  <= b_t1;
    end
  end

  // stage 2 combinational: region choice and dwell formulas
  region_e        rgn2;
  logic           sub2;
  logic [T_W-1:0] ta2, tb2, tc2;

  npc3_region_pick #(.TS(TS)) u_pick (
    .a_t   (a_t2),
    .b_t   (b_t2),
    .region(rgn2),
    .sub   (sub2),
    .ta    (ta2),
    .tb    (tb2),
    .tc    (tc2)
  );

  // stage 3 output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sector <= '0; out_region <= '0; out_sub <= 1'b0;
      out_ta <= '0; out_tb <= '0; out_tc <= '0;
    end else if (adv) begin
      out_valid  <= v2;
      out_sector <= sect2;
      out_region <= rgn2;
      out_sub    <= sub2;
      out_ta     <= ta2;
      out_tb     <= tb2;
      out_tc     <= tc2;
    end
  end
endmodule

// File: rtl/npc3_dwell_calc_chk.sv
module npc3_dwell_calc_chk #(
  parameter int TS  = 1000,
  parameter int T_W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2:0]     out_sector,
  input logic [1:0]     out_region,
  input logic           out_sub,
  input logic [T_W-1:0] out_ta,
  input logic [T_W-1:0] out_tb,
  input logic [T_W-1:0] out_tc
);
  p_sector_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sector < 3'd6);

  p_sum_ts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((T_W+2)'(out_ta) + (T_W+2)'(out_tb) + (T_W+2)'(out_tc)) == (T_W+2)'(TS));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_ta) <= TS && int'(out_tb) <= TS && int'(out_tc) <= TS));

  p_sub_outer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region >= 2'd2) |-> !out_sub);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sector) && $stable(out_region)
      && $stable(out_sub) && $stable(out_ta) && $stable(out_tb) && $stable(out_tc)));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);
endmodule

bind npc3_dwell_calc npc3_dwell_calc_chk #(.TS(TS), .T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sector(out_sector), .out_region(out_region),
  .out_sub(out_sub), .out_ta(out_ta), .out_tb(out_tb), .out_tc(out_tc)
);

// File: tb/npc3_dwell_calc_bench.sv
module npc3_dwell_calc_bench;
  localparam int TS  = 1000;
  localparam int ONE = 2048;
  localparam real PI = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_angle = '0;
  logic [11:0] in_ma = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [2:0] out_sector;
  logic [1:0] out_region;
  logic       out_sub;
  logic [9:0] out_ta, out_tb, out_tc;

  npc3_dwell_calc u_npc3_dwell_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .in_ma(in_ma), .out_valid(out_valid), .out_ready(out_ready),
    .out_sector(out_sector), .out_region(out_region), .out_sub(out_sub),
    .out_ta(out_ta), .out_tb(out_tb), .out_tc(out_tc)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    sector;
    int    region;
    int    sub;
    real   ta, tb, tc;
    bit    exact;
    int    acc_cyc;
    bit    timed;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   stall_mode = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, expv);
    end
  endtask

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  function automatic exp_t model(input int angle, input int ma, input string tag);
    exp_t e;
    int   w, th;
    real  m, tr, a, b, c, mg;
    w  = (angle >= 768) ? angle - 768 : angle;
    th = w % 128;
    e.sector = w / 128;
    m  = real'((ma > ONE) ? ONE : ma) / real'(ONE);
    tr = real'(th) * PI / 384.0;
    a  = 2.0 * m * $sin(tr);
    b  = 2.0 * m * $sin(PI / 3.0 - tr);
    c  = a + b;
    if (c <= 1.0) begin
      e.region = 0; e.ta = b; e.tb = 1.0 - c; e.tc = a;
    end else if (a <= 1.0 && b <= 1.0) begin
      e.region = 1; e.ta = 1.0 - a; e.tb = c - 1.0; e.tc = 1.0 - b;
    end else if (b >= 1.0) begin
      e.region = 2; e.ta = 2.0 - c; e.tb = a; e.tc = b - 1.0;
    end else begin
      e.region = 3; e.ta = a - 1.0; e.tb = b; e.tc = 2.0 - c;
    end
    e.ta = e.ta * TS; e.tb = e.tb * TS; e.tc = e.tc * TS;
    e.sub = (e.region < 2 && a > b) ? 1 : 0;
    mg = absr(c - 1.0);
    if (absr(a - 1.0) < mg) mg = absr(a - 1.0);
    if (absr(b - 1.0) < mg) mg = absr(b - 1.0);
    if (e.region < 2 && absr(a - b) < mg) mg = absr(a - b);
    e.exact = (mg > 0.01);
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input int angle, input int ma, input string tag);
    exp_t e;
    @(negedge clk);
    in_angle = 10'(angle);
    in_ma    = 12'(ma);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e = model(angle, ma, tag);
    e.acc_cyc = cyc;
    e.timed   = !stall_mode;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // ready driver
  always @(negedge clk) out_ready = !stall_mode || (cyc % 3 == 0);

  // monitor
  bit         held = 1'b0;
  logic [2:0] h_sec;
  logic [1:0] h_rgn;
  logic       h_sub;
  logic [9:0] h_ta, h_tb, h_tc;

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (held) begin
        check(out_valid && out_sector == h_sec && out_region == h_rgn && out_sub == h_sub
              && out_ta == h_ta && out_tb == h_tb && out_tc == h_tc,
              "R9", "held output changed", real'(out_ta), real'(h_ta));
        held = 1'b0;
      end
      if (out_valid && !out_ready) begin
        held = 1'b1;
        h_sec = out_sector; h_rgn = out_region; h_sub = out_sub;
        h_ta = out_ta; h_tb = out_tb; h_tc = out_tc;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected output", 1.0, 0.0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(out_sector) == e.sector, "R1", "sector", real'(out_sector), real'(e.sector));
          check(int'(out_ta) + int'(out_tb) + int'(out_tc) == TS, "R5", "sum",
                real'(int'(out_ta) + int'(out_tb) + int'(out_tc)), real'(TS));
          check(int'(out_ta) <= TS && int'(out_tb) <= TS && int'(out_tc) <= TS, "R6",
                "range", real'(out_ta), real'(TS));
          if (e.exact) begin
            check(int'(out_region) == e.region, "R3", "region", real'(out_region), real'(e.region));
            check(int'(out_sub) == e.sub, "R7", "sub", real'(out_sub), real'(e.sub));
            check(absr(real'(out_ta) - e.ta) <= 4.0, e.tag, "ta", real'(out_ta), e.ta);
            check(absr(real'(out_tb) - e.tb) <= 4.0, e.tag, "tb", real'(out_tb), e.tb);
            check(absr(real'(out_tc) - e.tc) <= 4.0, e.tag, "tc", real'(out_tc), e.tc);
          end
          if (e.timed && !stall_mode)
            check(cyc - e.acc_cyc == 3, "R10", "latency", real'(cyc - e.acc_cyc), 3.0);
        end
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired, expected drain of %0d items", q.size());
    finish_run();
  end

  task automatic drain;
    int guard;
    guard = 0;
    while (q.size() != 0 && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11", "out_valid in reset", real'(out_valid), 0.0);
    check(in_ready == 1'b1, "R11", "in_ready in reset", real'(in_ready), 1.0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", real'(out_valid), 0.0);

    // R1: sectors and wrap
    send(10, 1000, "R4");  send(140, 1000, "R4"); send(300, 1000, "R4");
    send(400, 1000, "R4"); send(530, 1000, "R4"); send(700, 1000, "R4");
    send(800, 1000, "R4"); send(1023, 1000, "R4");
    // R3 / R7: each region and sub-region
    send(20, 600, "R4");   send(100, 600, "R4");  // region 1 a, b
    send(50, 1229, "R4");  send(80, 1229, "R4");  // region 2 a, b
    send(10, 1946, "R4");  send(120, 1946, "R4"); // region 3, region 4
    send(0, 0, "R4");                             // zero index
    // R2: clamp
    send(200, 4000, "R2"); send(200, 2048, "R2"); send(90, 2049, "R2");
    // R8: centre of region 4
    send(105, 1806, "R8");
    drain();

    // sweep with free-running output
    seed = 12345;
    for (int i = 0; i < 200; i++) begin
      seed = seed * 1103515245 + 12345;
      send((seed >>> 8) & 1023, (seed >>> 3) & 2303, "R4");
    end
    drain();

    // back-pressure phase
    stall_mode = 1'b1;
    for (int i = 0; i < 100; i++) begin
      seed = seed * 1103515245 + 12345;
      send((seed >>> 8) & 767, (seed >>> 4) & 2047, "R4");
    end
    drain();
    stall_mode = 1'b0;
    repeat (4) @(posedge clk);
    check(q.size() == 0, "R10", "queue drained", real'(q.size()), 0.0);
    finish_run();
  end
endmodule